// File: doc/BRIEF.md
# GPIO Port Pad Controller

This block is one port of eight general-purpose pins. Software reaches it through a small register bank on a simple single-cycle read/write bus. Each pin has four settings: an output data bit, a two-bit drive mode, a pull-up disable bit, and a read-only level bit. The block turns each pin's mode and output bit into the three pad controls: driven value, output enable and pull-up enable. It also passes the incoming pad levels through a two-stage synchroniser, so software can read them back.

A pin in input mode does not drive its pad. A pin in push-pull mode drives its output bit directly. In open-drain mode the pin only ever pulls the pad low, and in open-source mode it only ever pulls the pad high; otherwise the pad is left released. The level register always shows the real pad level, so an output pin reads back what it drives. Read data is combinational from the presented address. A write takes effect at the clock edge on which it is presented.

Top module: `gpio_port_pad`

## Requirements
- R1: After reset all drive modes are input (code 00), the output data is 0 and the pull disable bits are 0. So padOe reads 0x00, padPullEn reads 0xFF, and the output data, mode and pull registers all read 0.
- R2: A write to offset 0x08 stores busWdata[7:0] as the output data. Reading 0x08 returns exactly that byte in bits [7:0], with bits [31:8] zero.
- R3: A write to offset 0x0C stores busWdata[15:0] as the pin modes, two bits per pin at bits [2n+1:2n]. Reading 0x0C returns those 16 bits, with bits [31:16] zero.
- R4: A write to offset 0x10 stores busWdata[7:0] as pull disable bits, where bit n = 1 turns off pin n's pull-up. Reading 0x10 returns the byte, and padPullEn[n] equals the inverse of bit n.
- R5: Reading offset 0x04 returns the pad levels in bits [7:0]. A pad change shows there after the second rising clock edge, not after the first, and this holds whatever the pin mode, so a driven pin reads its own level.
- R6: A pin with mode code 00 (input) has padOe low.
- R7: A pin with mode code 01 (push-pull) has padOe high, and padOut equals its output data bit.
- R8: A pin with mode code 10 (open-drain) has padOut low, and padOe high only when its output data bit is 0.
- R9: A pin with mode code 11 (open-source) has padOut high, and padOe high only when its output data bit is 1.
- R10: Writes to offset 0x04 or to any offset other than 0x04, 0x08, 0x0C and 0x10 change no register and no pad control. Reads of those other offsets return zero.
- R11: With busSel low, or with busWr low, no register changes. With busSel low, busRdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| padIn | input | 8 | Pad levels, asynchronous |
| padOut | output | 8 | Value to drive onto each pad |
| padOe | output | 8 | Output enable of each pad |
| padPullEn | output | 8 | Pull-up enable of each pad |

## Verification
The hardest situation to reach from the ports is a pin whose output data and mode were set by separate accesses, interleaved with writes to other pins' registers and to unmapped offsets. The per-pin drive translation must then combine the right mode bits with the right data bit. The random phase writes random values to random offsets, including unmapped ones. After every access it checks every pad control against a model of all three registers. A loopback phase feeds the driven pad value back into padIn. It confirms that an output pin reads its own level through the two-stage synchroniser, and that the level lags by exactly two edges.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

  localparam int PIN_COUNT = 8;
  localparam int MODE_W    = 2;
  localparam int BUS_AW    = 6;
  localparam int BUS_DW    = 32;

  typedef enum logic [MODE_W-1:0] {
    MODE_INPUT = 2'b00,
    MODE_PUSH  = 2'b01,
    MODE_SINK  = 2'b10,
    MODE_SRC   = 2'b11
  } pin_mode_e;

  localparam logic [BUS_AW-1:0] OFS_LEVEL = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_DRIVE = 6'h08;
  localparam logic [BUS_AW-1:0] OFS_MODE  = 6'h0C;
  localparam logic [BUS_AW-1:0] OFS_PULL  = 6'h10;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_LEVEL,
    RD_DRIVE,
    RD_MODE,
    RD_PULL
  } rd_sel_e;

  typedef struct packed {
    logic    wrDrive;
    logic    wrMode;
    logic    wrPull;
    rd_sel_e rdSel;
  } reg_strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int ADDR_W = BUS_AW
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output reg_strobe_t       strobe
);

  logic doWrite;
  logic doRead;

  assign doWrite = busSel & busWr;
  assign doRead  = busSel & ~busWr;

  always_comb begin
    strobe = '{wrDrive: 1'b0, wrMode: 1'b0, wrPull: 1'b0, rdSel: RD_NONE};
    case (busAddr)
      ADDR_W'(OFS_LEVEL): begin
        if (doRead) strobe.rdSel = RD_LEVEL;
      end
      ADDR_W'(OFS_DRIVE): begin
        strobe.wrDrive = doWrite;
        if (doRead) strobe.rdSel = RD_DRIVE;
      end
      ADDR_W'(OFS_MODE): begin
        strobe.wrMode = doWrite;
        if (doRead) strobe.rdSel = RD_MODE;
      end
      ADDR_W'(OFS_PULL): begin
        strobe.wrPull = doWrite;
        if (doRead) strobe.rdSel = RD_PULL;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_pad_pkg::*;
#(
  parameter int PINS       = PIN_COUNT,
  parameter int DATA_W     = BUS_DW,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  reg_strobe_t              strobe,
  input  logic [DATA_W-1:0]        busWdata,
  output logic [DATA_W-1:0]        busRdata,
  input  logic [PINS-1:0]          padIn,
  output logic [PINS-1:0]          padOut,
  output logic [PINS-1:0]          padOe,
  output logic [PINS-1:0]          padPullEn,
  output logic [MODE_W*PINS-1:0]   pinMode,
  output logic [PINS-1:0]          outData,
  output logic [PINS-1:0]          pullDis,
  output logic [PINS-1:0]          syncIn
);

  localparam int MODE_BITS = MODE_W * PINS;

  logic unusedWdata;
  assign unusedWdata = ^busWdata[DATA_W-1:MODE_BITS];

  // Level synchroniser chain
  logic [PINS-1:0] syncStage [SYNC_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncStage[0] <= '0;
    else       syncStage[0] <= padIn;
  end

  for (genvar s = 1; s < SYNC_DEPTH; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncStage[s] <= '0;
      else       syncStage[s] <= syncStage[s-1];
    end
  end

  assign syncIn = syncStage[SYNC_DEPTH-1];

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      pinMode <= '0;
      pullDis <= '0;
    end else begin
      if (strobe.wrDrive) outData <= busWdata[PINS-1:0];
      if (strobe.wrMode)  pinMode <= busWdata[MODE_BITS-1:0];
      if (strobe.wrPull)  pullDis <= busWdata[PINS-1:0];
    end
  end

  // Per-pin translation of mode to pad controls
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pin_mode_e pm;
    assign pm = pin_mode_e'(pinMode[MODE_W*p +: MODE_W]);

    always_comb begin
      case (pm)
        MODE_PUSH: begin
          padOut[p] = outData[p];
          padOe[p]  = 1'b1;
        end
        MODE_SINK: begin
          padOut[p] = 1'b0;
          padOe[p]  = ~outData[p];
        end
        MODE_SRC: begin
          padOut[p] = 1'b1;
          padOe[p]  = outData[p];
        end
        default: begin
          padOut[p] = outData[p];
          padOe[p]  = 1'b0;
        end
      endcase
    end

    assign padPullEn[p] = ~pullDis[p];
  end

  // Read mux
  always_comb begin
    case (strobe.rdSel)
      RD_LEVEL: busRdata = DATA_W'(syncIn);
      RD_DRIVE: busRdata = DATA_W'(outData);
      RD_MODE:  busRdata = DATA_W'(pinMode);
      RD_PULL:  busRdata = DATA_W'(pullDis);
      default:  busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_pad.sv
module gpio_port_pad
  import gpio_pad_pkg::*;
#(
  parameter int PINS       = PIN_COUNT,
  parameter int ADDR_W     = BUS_AW,
  parameter int DATA_W     = BUS_DW,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullEn
);

  reg_strobe_t              strobe;
  logic [MODE_W*PINS-1:0]   pinMode;
  logic [PINS-1:0]          outData;
  logic [PINS-1:0]          pullDis;
  logic [PINS-1:0]          syncIn;

  gpio_port_ctrl #(
    .ADDR_W (ADDR_W)
  ) i_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  gpio_port_datapath #(
    .PINS       (PINS),
    .DATA_W     (DATA_W),
    .SYNC_DEPTH (SYNC_DEPTH)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn),
    .pinMode   (pinMode),
    .outData   (outData),
    .pullDis   (pullDis),
    .syncIn    (syncIn)
  );

endmodule

// File: rtl/gpio_port_pad_chk.sv
module gpio_port_pad_chk
  import gpio_pad_pkg::*;
#(
  parameter int PINS       = PIN_COUNT,
  parameter int ADDR_W     = BUS_AW,
  parameter int DATA_W     = BUS_DW,
  parameter int SYNC_DEPTH = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busSel,
  input logic                   busWr,
  input logic [ADDR_W-1:0]      busAddr,
  input logic [DATA_W-1:0]      busWdata,
  input logic [PINS-1:0]        padIn,
  input logic [PINS-1:0]        padOut,
  input logic [PINS-1:0]        padOe,
  input logic [PINS-1:0]        padPullEn,
  input logic [MODE_W*PINS-1:0] pinMode,
  input logic [PINS-1:0]        outData,
  input logic [PINS-1:0]        pullDis,
  input logic [PINS-1:0]        syncIn
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic wrHit;
  assign wrHit = busSel && busWr;

  a_r2_drive_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr == ADDR_W'(OFS_DRIVE)) |=> outData == $past(busWdata[PINS-1:0]));

  a_r4_pull_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr == ADDR_W'(OFS_PULL)) |=> padPullEn == ~$past(busWdata[PINS-1:0]));

  a_r10_level_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && busAddr == ADDR_W'(OFS_LEVEL)) |=>
      ($stable(outData) && $stable(pinMode) && $stable(pullDis)));

  a_r11_no_select: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel) |=> ($stable(outData) && $stable(pinMode) && $stable(pullDis)));

  if (SYNC_DEPTH == 2) begin : g_sync_chk
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rstN)
      (cyc == 2'd3) |-> syncIn == $past(padIn, 2));
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin_chk
    logic [MODE_W-1:0] pm;
    assign pm = pinMode[MODE_W*p +: MODE_W];

    a_r6_input_released: assert property (@(posedge clk) disable iff (!rstN)
      (pm == 2'b00) |-> !padOe[p]);

    a_r7_push_pull: assert property (@(posedge clk) disable iff (!rstN)
      (pm == 2'b01) |-> (padOe[p] && padOut[p] == outData[p]));

    a_r8_open_drain: assert property (@(posedge clk) disable iff (!rstN)
      (pm == 2'b10) |-> (!padOut[p] && padOe[p] == !outData[p]));

    a_r9_open_source: assert property (@(posedge clk) disable iff (!rstN)
      (pm == 2'b11) |-> (padOut[p] && padOe[p] == outData[p]));
  end

endmodule

bind gpio_port_pad gpio_port_pad_chk #(
  .PINS       (PINS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .SYNC_DEPTH (SYNC_DEPTH)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .padIn     (padIn),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullEn (padPullEn),
  .pinMode   (pinMode),
  .outData   (outData),
  .pullDis   (pullDis),
  .syncIn    (syncIn)
);

// File: tb/test_gpio_port_pad.sv
module test_gpio_port_pad;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut;
  logic [7:0]  padOe;
  logic [7:0]  padPullEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0]  mDrive = '0;
  logic [15:0] mMode = '0;
  logic [7:0]  mPull = '0;

  always #2 clk = ~clk;

  gpio_port_pad i_gpio_port_pad (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullEn (padPullEn)
  );

  function automatic logic [7:0] expOe(input logic [15:0] m, input logic [7:0] d);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) begin
      case (m[2*p +: 2])
        2'b00: r[p] = 1'b0;
        2'b01: r[p] = 1'b1;
        2'b10: r[p] = ~d[p];
        default: r[p] = d[p];
      endcase
    end
    return r;
  endfunction

  // Returns the expected value per pin; input-mode pins take the actual value.
  function automatic logic [7:0] expOut(input logic [15:0] m, input logic [7:0] d,
                                        input logic [7:0] act);
    logic [7:0] r;
    for (int p = 0; p < 8; p++) begin
      case (m[2*p +: 2])
        2'b00: r[p] = act[p];
        2'b01: r[p] = d[p];
        2'b10: r[p] = 1'b0;
        default: r[p] = 1'b1;
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    case (a)
      6'h08: mDrive = d[7:0];
      6'h0C: mMode  = d[15:0];
      6'h10: mPull  = d[7:0];
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic checkRegs(input string req);
    logic [31:0] v;
    busRead(6'h08, v); check({req, " drive readback (R2)"}, v, {24'h0, mDrive});
    busRead(6'h0C, v); check({req, " mode readback (R3)"}, v, {16'h0, mMode});
    busRead(6'h10, v); check({req, " pull readback (R4)"}, v, {24'h0, mPull});
  endtask

  task automatic checkPads(input string req);
    check({req, " padOe (R6-R9 per mode)"}, {24'h0, padOe}, {24'h0, expOe(mMode, mDrive)});
    check({req, " padOut (R7 R8 R9)"}, {24'h0, padOut},
          {24'h0, expOut(mMode, mDrive, padOut)});
    check({req, " padPullEn (R4)"}, {24'h0, padPullEn}, {24'h0, ~mPull});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  a;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 padOe", {24'h0, padOe}, 32'h0);
    check("R1 padPullEn", {24'h0, padPullEn}, 32'hFF);
    busRead(6'h08, v); check("R1 drive", v, 32'h0);
    busRead(6'h0C, v); check("R1 mode", v, 32'h0);
    busRead(6'h10, v); check("R1 pull", v, 32'h0);

    // R2 R3 R4: upper bits dropped
    busWrite(6'h08, 32'hFFFF_FFA5);
    busWrite(6'h0C, 32'hFFFF_1B1B);
    busWrite(6'h10, 32'hFFFF_FFF0);
    checkRegs("directed");
    checkPads("directed mixed modes");
    check("R4 pull active-low", {24'h0, padPullEn}, 32'h0F);

    // R6-R9: every mode for both data values
    for (int m = 0; m < 4; m++) begin
      busWrite(6'h0C, {16'h0, {8{m[1:0]}}});
      busWrite(6'h08, 32'h0000_0055);
      checkPads("R6 R7 R8 R9 sweep d=55");
      busWrite(6'h08, 32'h0000_00AA);
      checkPads("R6 R7 R8 R9 sweep d=AA");
    end

    // R10: level register and unmapped offsets
    busWrite(6'h0C, 32'h0000_9C63);
    busWrite(6'h08, 32'h0000_003C);
    busWrite(6'h04, 32'hFFFF_FFFF);
    busWrite(6'h14, 32'hFFFF_FFFF);
    busWrite(6'h00, 32'hFFFF_FFFF);
    busWrite(6'h09, 32'hFFFF_FFFF);
    checkRegs("R10 after ignored writes");
    checkPads("R10 after ignored writes");
    busRead(6'h14, v); check("R10 unmapped read 0x14", v, 32'h0);
    busRead(6'h00, v); check("R10 unmapped read 0x00", v, 32'h0);
    busRead(6'h3C, v); check("R10 unmapped read 0x3C", v, 32'h0);

    // R11: no select, and read cycles, do not write
    busSel = 1'b0; busWr = 1'b1; busAddr = 6'h08; busWdata = 32'hC3;
    @(posedge clk); @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 6'h10; busWdata = 32'hFF;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0; busSel = 1'b0; busAddr = 6'h08;
    #1;
    check("R11 rdata with busSel low", busRdata, 32'h0);
    checkRegs("R11 after unselected write");

    // R5: two-stage latency
    padIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    padIn = 8'h3C;
    @(posedge clk); @(negedge clk);
    busRead(6'h04, v); check("R5 level after one edge", v, 32'h0);
    @(posedge clk); @(negedge clk);
    busRead(6'h04, v); check("R5 level after two edges", v, 32'h3C);

    // R5: loopback of driven level in push-pull, then open-drain with pull-up
    busWrite(6'h0C, 32'h0000_5555);
    busWrite(6'h08, 32'h0000_005A);
    padIn = padOut;
    repeat (2) @(posedge clk);
    @(negedge clk);
    busRead(6'h04, v); check("R5 push-pull loopback", v, 32'h5A);
    busWrite(6'h0C, 32'h0000_AAAA);
    busWrite(6'h10, 32'h0000_0000);
    padIn = (padOe & padOut) | (~padOe & padPullEn);
    repeat (2) @(posedge clk);
    @(negedge clk);
    busRead(6'h04, v); check("R5 open-drain loopback", v, 32'h5A);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 5))
        0: a = 6'h04;
        1: a = 6'h08;
        2: a = 6'h0C;
        3: a = 6'h10;
        4: a = 6'h08;
        default: a = 6'($urandom);
      endcase
      padIn = 8'($urandom);
      busWrite(a, $urandom);
      @(posedge clk); @(negedge clk);
      checkPads("random");
      if (i % 4 == 0) begin
        checkRegs("random");
        busRead(6'h04, v); check("R5 random level", v, {24'h0, padIn});
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule